// File: doc/BRIEF.md
# Device Function Configuration Header

This block holds the 256-byte configuration header of a single device function. A host-side access port presents a byte offset, an access width of one, two or four bytes and, for writes, a 32-bit data word. Reads return the addressed bytes packed little-endian in the same cycle. Writes land on the next clock edge after a write policy has filtered them. The policy applies size alignment to base address registers, protects identity and header bytes, and clears reserved command and status bits.

The protection applied to single bytes depends on the header layout byte held at offset 0x0E. That byte is loaded at reset and selects between an endpoint layout and a bridge layout (layout code 1 in its low seven bits). A one-cycle strobe tells the surrounding address decode logic to refresh whenever the command register or a base register has been written. In the bridge layout, the secondary bus number byte is also driven out on its own port.

Top module: `cfg_space`

## Requirements
- R1: After reset, offsets 0x00-0x01 hold VENDOR_ID, 0x02-0x03 DEVICE_ID, 0x08 REVISION, 0x09-0x0B CLASS_CODE (low byte first), 0x0E HDR_TYPE and every other byte is zero, except that an endpoint holds SUBSYS_VID/SUBSYS_ID at 0x2C-0x2F and a bridge (HDR_TYPE[6:0] = 1) holds 0x06 at 0x04, 0xA0 at 0x06, 0x10 at 0x0D and 0xA0 at 0x1E.
- R2: size_i encodes 0 = one byte, 1 = two bytes, 2 = four bytes. rdata_o returns the bytes at addr_i upward, least significant first and zero-extended. A two-byte access at 0xFF, a four-byte access above 0xFC, or size_i = 3 reads as 0xFFFFFFFF.
- R3: A four-byte write at a 4-aligned offset in 0x10-0x24 targets base register (offset-0x10)/4. If that register's BAR_LOG2 entry L is nonzero, it stores wdata_i with bits L-1..0 cleared.
- R4: A four-byte write at 0x30 with a nonzero BAR_LOG2[6] stores wdata_i with bits L-1..1 cleared and bit 0 kept.
- R5: In the endpoint layout, writes not taken by R3/R4 leave bytes 0x10-0x27, 0x2C-0x2F and 0x30-0x33 unchanged.
- R6: In the bridge layout, writes not taken by R3/R4 leave 0x2C-0x2F and 0x38-0x3B unchanged, while 0x10-0x27 and 0x30-0x33 accept them.
- R7: Bytes 0x00-0x03, 0x08-0x0B and 0x0E never change after reset.
- R8: Written command high byte (0x05) keeps only bits 2:0; status low byte (0x06) drops bits 2:0; status high byte (0x07) drops bits 2:1.
- R9: Writes outside the ranges in R2 or with size_i = 3 change nothing and raise no strobe.
- R10: map_upd_o is high for exactly the cycle after an in-range write that either touches offset 0x04 or 0x05 or is taken by R3/R4, and low otherwise.
- R11: In the bridge layout, sec_bus_o shows byte 0x19 and follows a write to it from the next cycle; in the endpoint layout it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write request this cycle |
| addr_i | input | 8 | Byte offset of the access |
| size_i | input | 2 | Access width code (R2) |
| wdata_i | input | 32 | Write data, little-endian |
| rdata_o | output | 32 | Read data for addr_i/size_i |
| map_upd_o | output | 1 | Decode refresh strobe |
| sec_bus_o | output | 8 | Secondary bus number (bridge layout) |

## Verification
The assertions assume the access port is driven with known values at every sampled edge, and that addr_i and size_i describe the access that rdata_o currently answers. They also assume HDR_TYPE, the identity parameters and the reset value of the header byte agree, because read-only checks compare the port against parameters. The bench changes its inputs only on the falling edge, so every port is settled well before the next rising edge. It also drives one shared stimulus stream into an endpoint instance and a bridge instance, which keeps both layouts covered by the same legal access sequence.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  typedef enum logic [1:0] {
    SZ_B1  = 2'd0,
    SZ_B2  = 2'd1,
    SZ_B4  = 2'd2,
    SZ_BAD = 2'd3
  } acc_size_e;

  localparam int unsigned NUM_BASE = 7;
  localparam int unsigned ROM_IDX  = 6;
  localparam int unsigned LANES    = 4;

  localparam logic [7:0] OFS_CMD     = 8'h04;
  localparam logic [7:0] OFS_CMD_HI  = 8'h05;
  localparam logic [7:0] OFS_STS_LO  = 8'h06;
  localparam logic [7:0] OFS_STS_HI  = 8'h07;
  localparam logic [7:0] OFS_HDR     = 8'h0E;
  localparam logic [7:0] OFS_SEC_BUS = 8'h19;
  localparam logic [7:0] OFS_ROM     = 8'h30;

  localparam logic [7:0] CMD_HI_RSV = 8'hF8;
  localparam logic [7:0] STS_LO_RSV = 8'h07;
  localparam logic [7:0] STS_HI_RSV = 8'h06;

  function automatic logic [2:0] acc_len(logic [1:0] sz);
    case (sz)
      SZ_B1:   return 3'd1;
      SZ_B2:   return 3'd2;
      SZ_B4:   return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic acc_in_range(logic [7:0] a, logic [1:0] sz);
    case (sz)
      SZ_B1:   return 1'b1;
      SZ_B2:   return a != 8'hFF;
      SZ_B4:   return a <= 8'hFC;
      default: return 1'b0;
    endcase
  endfunction

  // byte-path write protection, chosen by header layout
  function automatic logic byte_locked(logic [7:0] b, logic bridge);
    logic common, ep_only, br_only;
    common  = (b <= 8'h03) || (b >= 8'h08 && b <= 8'h0B) || (b == OFS_HDR) ||
              (b >= 8'h2C && b <= 8'h2F);
    ep_only = (b >= 8'h10 && b <= 8'h27) || (b >= 8'h30 && b <= 8'h33);
    br_only = (b >= 8'h38 && b <= 8'h3B);
    return common || (bridge ? br_only : ep_only);
  endfunction

  function automatic logic [7:0] byte_clean(logic [7:0] b, logic [7:0] d);
    case (b)
      OFS_CMD_HI: return d & ~CMD_HI_RSV;
      OFS_STS_LO: return d & ~STS_LO_RSV;
      OFS_STS_HI: return d & ~STS_HI_RSV;
      default:    return d;
    endcase
  endfunction
endpackage

// File: rtl/cfg_wr_policy.sv
module cfg_wr_policy
  import cfg_pkg::*;
#(
  parameter logic [NUM_BASE-1:0][4:0] BAR_LOG2 = '0
) (
  input  logic                  wr_en_i,
  input  logic [7:0]            addr_i,
  input  logic [1:0]            size_i,
  input  logic [31:0]           wdata_i,
  input  logic                  bridge_i,
  output logic [LANES-1:0]      lane_we_o,
  output logic [LANES-1:0][7:0] lane_addr_o,
  output logic [LANES-1:0][7:0] lane_data_o,
  output logic                  touch_o
);
  logic [2:0]       len;
  logic             acc_ok;
  logic             base_hit;
  logic [2:0]       base_idx;
  logic [4:0]       sz_log2;
  logic             base_path;
  logic [31:0]      keep_mask;
  logic [31:0]      base_val;
  logic [LANES-1:0] cmd_hit;

  assign len    = acc_len(size_i);
  assign acc_ok = wr_en_i && acc_in_range(addr_i, size_i);

  always_comb begin
    base_hit = 1'b0;
    base_idx = 3'd0;
    if (size_i == SZ_B4 && addr_i[1:0] == 2'b00) begin
      if (addr_i >= 8'h10 && addr_i <= 8'h24) begin
        base_hit = 1'b1;
        base_idx = 3'(addr_i[7:2] - 6'd4);
      end else if (addr_i == OFS_ROM) begin
        base_hit = 1'b1;
        base_idx = 3'(ROM_IDX);
      end
    end
  end

  assign sz_log2   = BAR_LOG2[base_idx];
  assign base_path = acc_ok && base_hit && (sz_log2 != 5'd0);
  assign keep_mask = ~((32'd1 << sz_log2) - 32'd1);
  assign base_val  = (wdata_i & keep_mask) |
                     ((base_idx == 3'(ROM_IDX)) ? {31'd0, wdata_i[0]} : 32'd0);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic       lane_act;
    logic [7:0] b_addr;
    logic [7:0] b_in;
    assign b_addr         = addr_i + 8'(k);
    assign b_in           = wdata_i[8*k +: 8];
    assign lane_act       = acc_ok && (3'(k) < len);
    assign lane_addr_o[k] = b_addr;
    assign lane_we_o[k]   = base_path || (lane_act && !byte_locked(b_addr, bridge_i));
    assign lane_data_o[k] = base_path ? base_val[8*k +: 8] : byte_clean(b_addr, b_in);
    assign cmd_hit[k]     = lane_act && (b_addr == OFS_CMD || b_addr == OFS_CMD_HI);
  end

  assign touch_o = base_path || (|cmd_hit);
endmodule

// File: rtl/cfg_rd_align.sv
module cfg_rd_align
  import cfg_pkg::*;
(
  input  logic [7:0]            addr_i,
  input  logic [1:0]            size_i,
  input  logic [LANES-1:0][7:0] bytes_i,
  output logic [31:0]           rdata_o
);
  always_comb begin
    if (!acc_in_range(addr_i, size_i)) begin
      rdata_o = '1;
    end else begin
      case (size_i)
        SZ_B1:   rdata_o = {24'd0, bytes_i[0]};
        SZ_B2:   rdata_o = {16'd0, bytes_i[1], bytes_i[0]};
        default: rdata_o = bytes_i;
      endcase
    end
  end
endmodule

// File: rtl/cfg_space.sv
module cfg_space
  import cfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'hC0DE,
  parameter logic [15:0] DEVICE_ID  = 16'h0042,
  parameter logic [7:0]  REVISION   = 8'h01,
  parameter logic [23:0] CLASS_CODE = 24'h020000,
  parameter logic [7:0]  HDR_TYPE   = 8'h00,
  parameter logic [15:0] SUBSYS_VID = 16'h0000,
  parameter logic [15:0] SUBSYS_ID  = 16'h0000,
  parameter logic [NUM_BASE-1:0][4:0] BAR_LOG2 =
    {5'd11, 5'd0, 5'd0, 5'd0, 5'd0, 5'd12, 5'd4}
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [7:0]  addr_i,
  input  logic [1:0]  size_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        map_upd_o,
  output logic [7:0]  sec_bus_o
);
  localparam int unsigned SPACE_BYTES = 256;
  localparam logic        IS_BRIDGE   = (HDR_TYPE[6:0] == 7'd1);

  function automatic logic [7:0] reset_byte(int unsigned i);
    case (8'(i))
      8'h00: return VENDOR_ID[7:0];
      8'h01: return VENDOR_ID[15:8];
      8'h02: return DEVICE_ID[7:0];
      8'h03: return DEVICE_ID[15:8];
      8'h04: return IS_BRIDGE ? 8'h06 : 8'h00;
      8'h06: return IS_BRIDGE ? 8'hA0 : 8'h00;
      8'h08: return REVISION;
      8'h09: return CLASS_CODE[7:0];
      8'h0A: return CLASS_CODE[15:8];
      8'h0B: return CLASS_CODE[23:16];
      8'h0D: return IS_BRIDGE ? 8'h10 : 8'h00;
      8'h0E: return HDR_TYPE;
      8'h1E: return IS_BRIDGE ? 8'hA0 : 8'h00;
      8'h2C: return IS_BRIDGE ? 8'h00 : SUBSYS_VID[7:0];
      8'h2D: return IS_BRIDGE ? 8'h00 : SUBSYS_VID[15:8];
      8'h2E: return IS_BRIDGE ? 8'h00 : SUBSYS_ID[7:0];
      8'h2F: return IS_BRIDGE ? 8'h00 : SUBSYS_ID[15:8];
      default: return 8'h00;
    endcase
  endfunction

  logic [7:0]            cfg_q [SPACE_BYTES];
  logic                  bridge_now;
  logic [LANES-1:0]      lane_we;
  logic [LANES-1:0][7:0] lane_addr;
  logic [LANES-1:0][7:0] lane_data;
  logic [LANES-1:0][7:0] rd_bytes;
  logic                  touch;
  logic                  map_upd_q;

  assign bridge_now = (cfg_q[OFS_HDR][6:0] == 7'd1);

  cfg_wr_policy #(.BAR_LOG2(BAR_LOG2)) u_wr_policy (
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .size_i     (size_i),
    .wdata_i    (wdata_i),
    .bridge_i   (bridge_now),
    .lane_we_o  (lane_we),
    .lane_addr_o(lane_addr),
    .lane_data_o(lane_data),
    .touch_o    (touch)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int unsigned i = 0; i < SPACE_BYTES; i++) cfg_q[i] <= reset_byte(i);
    end else begin
      for (int k = 0; k < LANES; k++) begin
        if (lane_we[k]) cfg_q[lane_addr[k]] <= lane_data[k];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) map_upd_q <= 1'b0;
    else         map_upd_q <= touch;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_rd
    assign rd_bytes[k] = cfg_q[addr_i + 8'(k)];
  end

  cfg_rd_align u_rd_align (
    .addr_i (addr_i),
    .size_i (size_i),
    .bytes_i(rd_bytes),
    .rdata_o(rdata_o)
  );

  assign map_upd_o = map_upd_q;
  assign sec_bus_o = bridge_now ? cfg_q[OFS_SEC_BUS] : 8'h00;
endmodule

// File: rtl/cfg_space_chk.sv
module cfg_space_chk #(
  parameter logic [15:0] VENDOR_ID = 16'h0,
  parameter logic [15:0] DEVICE_ID = 16'h0,
  parameter logic [7:0]  HDR_TYPE  = 8'h0
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [7:0]  addr_i,
  input logic [1:0]  size_i,
  input logic [31:0] rdata_o,
  input logic        map_upd_o,
  input logic [7:0]  sec_bus_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  // R10: strobe only follows a write
  a_r10_strobe_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen_q)
    map_upd_o |-> $past(wr_en_i));

  // R11: secondary bus number moves only after a write
  a_r11_secbus_stable: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen_q)
    !$past(wr_en_i) |-> $stable(sec_bus_o));

  // R2: out-of-range reads return all ones
  a_r2_oor_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((size_i == 2'd2 && addr_i > 8'hFC) || (size_i == 2'd1 && addr_i == 8'hFF) || size_i == 2'd3)
    |-> rdata_o == 32'hFFFF_FFFF);

  // R1, R7: identity word stays at its parameter value
  a_r7_identity_const: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 8'h00 && size_i == 2'd2) |-> rdata_o == {DEVICE_ID, VENDOR_ID});

  // R7: header layout byte is fixed
  a_r7_hdr_const: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 8'h0E && size_i == 2'd0) |-> rdata_o == {24'd0, HDR_TYPE});
endmodule

bind cfg_space cfg_space_chk #(
  .VENDOR_ID(VENDOR_ID),
  .DEVICE_ID(DEVICE_ID),
  .HDR_TYPE (HDR_TYPE)
) u_chk (.*);

// File: tb/cfg_space_tb_top.sv
`timescale 1ns/1ps
module cfg_space_tb_top;
  localparam int HALF = 10;  // 50 MHz
  localparam int WD_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata [2];
  logic        map_upd [2];
  logic [7:0]  sec_bus [2];

  int total = 0;
  int fails = 0;
  bit done = 0;

  always #HALF clk = ~clk;

  cfg_space #(
    .VENDOR_ID(16'hC0DE), .DEVICE_ID(16'h0042), .REVISION(8'h03),
    .CLASS_CODE(24'h020000), .HDR_TYPE(8'h00),
    .SUBSYS_VID(16'h5A5A), .SUBSYS_ID(16'hA5A5),
    .BAR_LOG2({5'd11, 5'd0, 5'd0, 5'd0, 5'd0, 5'd12, 5'd4})
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .size_i(size),
    .wdata_i(wdata), .rdata_o(rdata[0]), .map_upd_o(map_upd[0]), .sec_bus_o(sec_bus[0])
  );

  cfg_space #(
    .VENDOR_ID(16'hB00B), .DEVICE_ID(16'h0007), .REVISION(8'h02),
    .CLASS_CODE(24'h060400), .HDR_TYPE(8'h81),
    .SUBSYS_VID(16'h1111), .SUBSYS_ID(16'h2222),
    .BAR_LOG2({5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd8})
  ) dut_br_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .size_i(size),
    .wdata_i(wdata), .rdata_o(rdata[1]), .map_upd_o(map_upd[1]), .sec_bus_o(sec_bus[1])
  );

  // reference model: index 0 endpoint, 1 bridge
  logic [7:0] mem_m [2][256];
  int         log2_m [2][7] = '{'{4, 12, 0, 0, 0, 0, 11}, '{8, 0, 0, 0, 0, 0, 0}};
  bit         exp_map [2];

  function automatic void m_reset();
    for (int u = 0; u < 2; u++) for (int i = 0; i < 256; i++) mem_m[u][i] = 8'h00;
    mem_m[0][0] = 8'hDE; mem_m[0][1] = 8'hC0; mem_m[0][2] = 8'h42; mem_m[0][3] = 8'h00;
    mem_m[0][8] = 8'h03; mem_m[0][9] = 8'h00; mem_m[0][10] = 8'h00; mem_m[0][11] = 8'h02;
    mem_m[0][14] = 8'h00;
    mem_m[0][44] = 8'h5A; mem_m[0][45] = 8'h5A; mem_m[0][46] = 8'hA5; mem_m[0][47] = 8'hA5;
    mem_m[1][0] = 8'h0B; mem_m[1][1] = 8'hB0; mem_m[1][2] = 8'h07; mem_m[1][3] = 8'h00;
    mem_m[1][4] = 8'h06; mem_m[1][6] = 8'hA0; mem_m[1][8] = 8'h02;
    mem_m[1][9] = 8'h00; mem_m[1][10] = 8'h04; mem_m[1][11] = 8'h06;
    mem_m[1][13] = 8'h10; mem_m[1][14] = 8'h81; mem_m[1][30] = 8'hA0;
  endfunction

  function automatic int m_len(int sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : (sz == 2) ? 4 : 0;
  endfunction

  function automatic logic [31:0] m_read(int u, int a, int sz);
    int n = m_len(sz);
    logic [31:0] v = 32'd0;
    if (n == 0 || a + n > 256) return 32'hFFFF_FFFF;
    for (int k = 0; k < n; k++) v[8*k +: 8] = mem_m[u][a + k];
    return v;
  endfunction

  function automatic bit m_locked(int u, int b);
    if (b <= 3 || (b >= 8 && b <= 11) || b == 14 || (b >= 44 && b <= 47)) return 1;
    if (u == 0) return (b >= 16 && b <= 39) || (b >= 48 && b <= 51);
    return b >= 56 && b <= 59;
  endfunction

  function automatic bit m_write(int u, int a, int sz, logic [31:0] d);
    int n = m_len(sz);
    bit hit = 0;
    if (n == 0 || a + n > 256) return 0;
    if (n == 4 && a % 4 == 0 && ((a >= 16 && a <= 36) || a == 48)) begin
      int idx = (a == 48) ? 6 : (a - 16) / 4;
      int l = log2_m[u][idx];
      if (l != 0) begin
        logic [31:0] v = d & ~((32'd1 << l) - 32'd1);
        if (idx == 6) v[0] = d[0];
        for (int k = 0; k < 4; k++) mem_m[u][a + k] = v[8*k +: 8];
        return 1;
      end
    end
    for (int k = 0; k < n; k++) begin
      int b = a + k;
      logic [7:0] by = d[8*k +: 8];
      if (b == 4 || b == 5) hit = 1;
      if (!m_locked(u, b)) begin
        if (b == 5) by &= 8'h07;
        if (b == 6) by &= 8'hF8;
        if (b == 7) by &= 8'hF9;
        mem_m[u][b] = by;
      end
    end
    return hit;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // drive at falling edge, check read, clock, check strobe and bus
  task automatic op(bit we, int a, int sz, logic [31:0] d, string tag);
    wr_en = we; addr = 8'(a); size = 2'(sz); wdata = d;
    #2;
    chk(tag, "ep rdata", rdata[0], m_read(0, a, sz));
    chk(tag, "br rdata", rdata[1], m_read(1, a, sz));
    @(posedge clk);
    for (int u = 0; u < 2; u++) exp_map[u] = we ? m_write(u, a, sz, d) : 1'b0;
    @(negedge clk);
    chk(tag, "ep map_upd", {31'd0, map_upd[0]}, {31'd0, exp_map[0]});
    chk(tag, "br map_upd", {31'd0, map_upd[1]}, {31'd0, exp_map[1]});
    chk(tag, "ep sec_bus", {24'd0, sec_bus[0]}, 32'd0);
    chk(tag, "br sec_bus", {24'd0, sec_bus[1]}, {24'd0, mem_m[1][8'h19]});
    wr_en = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL R1 watchdog: actual %0d expected %0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr = 32'hACE1_2468;
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset contents
    chk("R1", "ep map_upd idle", {31'd0, map_upd[0]}, 32'd0);
    chk("R11", "ep sec_bus reset", {24'd0, sec_bus[0]}, 32'd0);
    op(0, 8'h00, 2, 0, "R1");
    op(0, 8'h04, 2, 0, "R1");
    op(0, 8'h08, 2, 0, "R1");
    op(0, 8'h0C, 2, 0, "R1");
    op(0, 8'h1C, 2, 0, "R1");
    op(0, 8'h2C, 2, 0, "R1");
    // R2 widths
    op(0, 8'h01, 1, 0, "R2");
    op(0, 8'h0A, 0, 0, "R2");
    op(0, 8'hFC, 2, 0, "R2");
    op(0, 8'hFE, 1, 0, "R2");
    op(0, 8'hFD, 2, 0, "R2");
    op(0, 8'hFF, 1, 0, "R2");
    op(0, 8'h10, 3, 0, "R2");
    // R3 base alignment
    op(1, 8'h10, 2, 32'hFFFF_FFFF, "R3");
    op(0, 8'h10, 2, 0, "R3");
    op(1, 8'h14, 2, 32'h1234_5678, "R3");
    op(0, 8'h14, 2, 0, "R3");
    op(1, 8'h18, 2, 32'hDEAD_BEEF, "R3");
    op(0, 8'h18, 2, 0, "R3");
    // R4 ROM enable bit
    op(1, 8'h30, 2, 32'hFFFF_FFFF, "R4");
    op(0, 8'h30, 2, 0, "R4");
    op(1, 8'h30, 2, 32'h0001_2345, "R4");
    op(0, 8'h30, 2, 0, "R4");
    // R5 / R6 byte protection
    op(1, 8'h11, 0, 32'h77, "R5");
    op(0, 8'h10, 2, 0, "R5");
    op(1, 8'h12, 2, 32'hCAFE_F00D, "R5");
    op(0, 8'h10, 2, 0, "R5");
    op(0, 8'h14, 2, 0, "R5");
    op(1, 8'h32, 1, 32'hBEEF, "R5");
    op(0, 8'h30, 2, 0, "R5");
    op(1, 8'h2C, 1, 32'h9999, "R6");
    op(0, 8'h2C, 2, 0, "R6");
    op(1, 8'h38, 0, 32'h44, "R6");
    op(0, 8'h38, 2, 0, "R6");
    op(1, 8'h3A, 1, 32'h6655, "R6");
    op(0, 8'h38, 2, 0, "R6");
    // R7 read-only bytes
    op(1, 8'h00, 2, 32'h0, "R7");
    op(0, 8'h00, 2, 0, "R7");
    op(1, 8'h08, 2, 32'hFFFF_FFFF, "R7");
    op(0, 8'h08, 2, 0, "R7");
    op(1, 8'h0E, 0, 32'h01, "R7");
    op(0, 8'h0C, 2, 0, "R7");
    // R8 reserved bits, R10 strobe
    op(1, 8'h04, 1, 32'hFFFF, "R8");
    op(0, 8'h04, 2, 0, "R8");
    op(1, 8'h06, 1, 32'hFFFF, "R8");
    op(0, 8'h04, 2, 0, "R8");
    op(1, 8'h05, 0, 32'hFF, "R10");
    op(1, 8'h03, 1, 32'h0000, "R10");
    op(1, 8'h06, 0, 32'h00, "R10");
    op(1, 8'h04, 2, 32'h0000_0000, "R10");
    // R9 discarded writes
    op(1, 8'hFE, 2, 32'h1122_3344, "R9");
    op(0, 8'hFC, 2, 0, "R9");
    op(1, 8'h04, 3, 32'hFFFF_FFFF, "R9");
    op(0, 8'h04, 2, 0, "R9");
    op(1, 8'hFF, 1, 32'h5555, "R9");
    op(0, 8'hFE, 1, 0, "R9");
    // R11 secondary bus number
    op(1, 8'h19, 0, 32'h5A, "R11");
    op(1, 8'h18, 2, 32'h0012_3400, "R11");
    op(0, 8'h18, 2, 0, "R11");
    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      int a;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = lfsr[7] ? int'(lfsr[15:8]) : int'(lfsr[13:8] & 6'h3F);
      if (lfsr[20]) a = a & 8'hFC;
      op(lfsr[3], a, int'(lfsr[5:4]), {lfsr[23:16], lfsr[31:24], lfsr[15:0]}, "R2");
    end
    done = 1;
    summary();
    $finish;
  end
endmodule